// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Controller

This block is a clocked model of the write engine of a byte-wide EEPROM. A host drives a select, a write enable, an output enable, an address and a data byte. A write access is recognised only when the write enable stays high long enough to pass a glitch filter. The first accepted byte opens a page load. Later bytes for the same page go into a page buffer, and each one restarts an idle timer. When the timer runs out, the load closes and a programming cycle of fixed length begins. That cycle copies only the buffered bytes into the memory array.

While programming is under way, a read returns a status byte instead of array data. The top bit is the inverse of the top bit of the last byte loaded. The next bit flips on every new read access. The remaining bits carry the last byte unchanged. Once the cycle ends, reads return array contents again. The page size, the filter width, the load idle timeout and the programming length are all parameters, counted in clock cycles.

Top module: `pgw_ctrl`

## Requirements
- R1: After reset `busy` is 0 and `rdata` is 0. The array powers up all zero, so a read of any location that was never programmed returns 0x00.
- R2: A write access is `sel`=1, `wen`=1, `oen`=0. It is accepted only if that condition holds for at least MIN_PULSE (default 3) consecutive clock cycles. A shorter pulse is dropped. A longer pulse is accepted once.
- R3: No write is accepted while `oen`=1, `wen`=0 or `sel`=0.
- R4: An accepted byte in idle opens a page load. Each further accepted byte of the same page restarts the idle timer. When LOAD_IDLE (default 200) cycles pass with no such byte, programming starts and `busy` rises.
- R5: Address bits [6:0] select the byte within the page, and the upper bits select the page. During a load, a byte whose page differs from the first byte's page is dropped and does not restart the idle timer.
- R6: Programming keeps `busy` high for exactly PROG_CYCLES (default 400) cycles. After that, every byte loaded in the window reads back from the array.
- R7: Locations of the page that were not loaded in the window keep their previous contents.
- R8: Write accesses during programming are ignored. They change no array location and do not open a new load after the cycle ends.
- R9: A read during programming returns bit 7 equal to the inverse of bit 7 of the last loaded byte, and bits 5:0 equal to bits 5:0 of that byte.
- R10: During programming, bit 6 of the status is 0 on the first read access and flips on each later access. After programming ends, reads return true array data.
- R11: When the same address is loaded twice in one window, the later byte is the one committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Device select, active high |
| wen | input | 1 | Write enable, active high |
| oen | input | 1 | Output enable, active high; a read is sel=1, oen=1, wen=0 |
| addr | input | ADDR_W | Byte address; bits [6:0] index within the page |
| wdata | input | DATA_W | Write data byte |
| rdata | output | DATA_W | Read data, registered; 0 when no read is active |
| busy | output | 1 | High for the whole programming cycle |

## Verification
The load engine is driven with several kinds of input. Byte trains spaced at half the idle timeout show that the window restarts. A byte for a foreign page, sent late in a window, tells a dropped byte that restarts the timer apart from one that does not. Pulses one cycle short of the filter width, and at exactly that width, bound the glitch filter. Gated strobes (output enable on, select off, write enable off) must leave the array untouched. A second load that touches only some bytes of a page, and a load that writes one address twice, separate selective commits from whole-page commits and from first-write-wins behaviour. Status reads made back to back during programming, with last bytes whose top bit is 1 and 0, check the inverted bit and the toggle sequence before true data comes back.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgw_state_e;
endpackage

// File: rtl/pgw_strobe.sv
// Glitch filter on the write strobe: accepts one byte per qualifying pulse.
module pgw_strobe #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int MIN_PULSE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wen,
  input  logic              oen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              acc_v,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_data
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic          cond;
  logic [CW-1:0] run;

  assign cond = sel && wen && !oen;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= '0;
      acc_v    <= 1'b0;
      acc_addr <= '0;
      acc_data <= '0;
    end else begin
      acc_v <= 1'b0;
      if (cond) begin
        if (run != CW'(MIN_PULSE)) run <= run + 1'b1;
        if (run == CW'(MIN_PULSE - 1)) begin
          acc_v    <= 1'b1;
          acc_addr <= addr;
          acc_data <= din;
        end
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/pgw_pagebuf.sv
// Page buffer with one loaded flag per byte.
module pgw_pagebuf #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128,
  localparam int IW        = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld
);
  logic [DATA_W-1:0]     store [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  assign rd_data = store[rd_idx];
  assign rd_vld  = vld[rd_idx];
endmodule

// File: rtl/pgw_array.sv
// Simple dual-port array, synchronous read, shaped for block RAM inference.
module pgw_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata_q <= cells[raddr];
  end
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 128,
  parameter int MIN_PULSE   = 3,
  parameter int LOAD_IDLE   = 200,
  parameter int PROG_CYCLES = 400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wen,
  input  logic              oen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  localparam int IW = $clog2(PAGE_BYTES);
  localparam int PW = ADDR_W - IW;
  localparam int TW = $clog2(LOAD_IDLE);
  localparam int CW = $clog2(PROG_CYCLES);

  // strobe filter
  logic              acc_v;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_data;

  pgw_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) strobe_i (
    .clk(clk), .rst(rst), .sel(sel), .wen(wen), .oen(oen),
    .addr(addr), .din(wdata),
    .acc_v(acc_v), .acc_addr(acc_addr), .acc_data(acc_data)
  );

  // load / program sequencer
  pgw_state_e        state;
  logic              busy_q;
  logic [PW-1:0]     page_q;
  logic [TW-1:0]     timer;
  logic [CW-1:0]     pcnt;
  logic [DATA_W-1:0] last_q;
  logic [PW-1:0]     acc_page;
  logic              page_hit;
  logic              buf_wr;
  logic              buf_clr;
  logic              seq_on;
  logic [IW-1:0]     seq_idx;
  logic [DATA_W-1:0] buf_q;
  logic              buf_vld;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr;
  logic [DATA_W-1:0] mem_q;

  assign acc_page = acc_addr[ADDR_W-1:IW];
  assign page_hit = (acc_page == page_q);
  assign buf_wr   = acc_v && ((state == ST_IDLE) || ((state == ST_LOAD) && page_hit));
  assign buf_clr  = (state == ST_PROG) && (pcnt == CW'(PROG_CYCLES - 1));
  assign seq_on   = (state == ST_PROG) && (pcnt < CW'(PAGE_BYTES));
  assign seq_idx  = pcnt[IW-1:0];
  assign arr_we   = seq_on && buf_vld;
  assign arr_waddr = {page_q, seq_idx};

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      busy_q <= 1'b0;
      page_q <= '0;
      timer  <= '0;
      pcnt   <= '0;
      last_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (acc_v) begin
            state  <= ST_LOAD;
            page_q <= acc_page;
            timer  <= '0;
            last_q <= acc_data;
          end
        end
        ST_LOAD: begin
          if (acc_v && page_hit) begin
            timer  <= '0;
            last_q <= acc_data;
          end else if (timer == TW'(LOAD_IDLE - 1)) begin
            state  <= ST_PROG;
            busy_q <= 1'b1;
            pcnt   <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_PROG: begin
          if (pcnt == CW'(PROG_CYCLES - 1)) begin
            state  <= ST_IDLE;
            busy_q <= 1'b0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  pgw_pagebuf #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) pbuf_i (
    .clk(clk), .rst(rst), .clr(buf_clr),
    .wr_en(buf_wr), .wr_idx(acc_addr[IW-1:0]), .wr_data(acc_data),
    .rd_idx(seq_idx), .rd_data(buf_q), .rd_vld(buf_vld)
  );

  pgw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(buf_q),
    .raddr(addr), .rdata_q(mem_q)
  );

  // read path with status substitution
  logic rd_cond, rd_prev, rd_start, rd_s1, busy_s1, tog, tog_s1;

  assign rd_cond  = sel && oen && !wen;
  assign rd_start = rd_cond && !rd_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev <= 1'b0;
      rd_s1   <= 1'b0;
      busy_s1 <= 1'b0;
      tog     <= 1'b0;
      tog_s1  <= 1'b0;
      rdata   <= '0;
    end else begin
      rd_prev <= rd_cond;
      rd_s1   <= rd_cond;
      busy_s1 <= busy_q;
      if (rd_start) tog_s1 <= tog;
      if (!busy_q) tog <= 1'b0;
      else if (rd_start) tog <= !tog;
      if (!rd_s1) rdata <= '0;
      else if (busy_s1) rdata <= {!last_q[DATA_W-1], tog_s1, last_q[DATA_W-3:0]};
      else rdata <= mem_q;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/pgw_ctrl_chk.sv
module pgw_ctrl_chk #(
  parameter int DATA_W      = 8,
  parameter int MIN_PULSE   = 3,
  parameter int PROG_CYCLES = 400
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              wen,
  input logic              oen,
  input logic              busy,
  input logic              acc_v,
  input logic              arr_we,
  input logic [DATA_W-1:0] last_q
);
  localparam int RW = $clog2(MIN_PULSE + 1);
  localparam int BW = $clog2(PROG_CYCLES + 1) + 1;

  logic          wcond;
  logic [RW-1:0] run;
  logic [BW-1:0] bcnt;

  assign wcond = sel && wen && !oen;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      bcnt <= '0;
    end else begin
      run  <= wcond ? ((run == RW'(MIN_PULSE)) ? run : run + 1'b1) : '0;
      bcnt <= busy ? bcnt + 1'b1 : '0;
    end
  end

  AST_PULSE_MIN: assert property (@(posedge clk) disable iff (rst)
    acc_v |-> (run >= RW'(MIN_PULSE))); // R2
  AST_WRITE_GATE: assert property (@(posedge clk) disable iff (rst)
    acc_v |-> $past(sel && wen && !oen)); // R3
  AST_PROG_LEN: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bcnt < BW'(PROG_CYCLES))); // R6
  AST_PROG_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == BW'(PROG_CYCLES))); // R6
  AST_ARRAY_WR_BUSY: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy); // R7
  AST_LAST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(last_q)); // R8
endmodule

bind pgw_ctrl pgw_ctrl_chk #(
  .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE), .PROG_CYCLES(PROG_CYCLES)
) chk_i (
  .clk(clk), .rst(rst), .sel(sel), .wen(wen), .oen(oen),
  .busy(busy), .acc_v(acc_v), .arr_we(arr_we), .last_q(last_q)
);

// File: tb/pgw_ctrl_tb_top.sv
`timescale 1ns/1ps
module pgw_ctrl_tb_top;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int MINP   = 3;
  localparam int LIDLE  = 200;
  localparam int PCYC   = 400;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sel = 1'b0, wen = 1'b0, oen = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              busy;

  always #10 clk = ~clk; // 50 MHz

  pgw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(128),
             .MIN_PULSE(MINP), .LOAD_IDLE(LIDLE), .PROG_CYCLES(PCYC)) dut_i (
    .clk(clk), .rst(rst), .sel(sel), .wen(wen), .oen(oen),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  typedef struct {
    logic [7:0] exp;
    bit         is_busy;
    string      tag;
  } sb_item_t;

  sb_item_t sb[$];
  int  checks = 0;
  int  errors = 0;
  bit  mon_go = 1'b0;
  bit  done   = 1'b0;
  int  cyc    = 0;

  // monitor: pops one expected item per request and compares
  always @(negedge clk) begin
    if (mon_go) begin
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty act=%h exp=none", rdata);
      end else begin
        sb_item_t it;
        logic [7:0] act;
        it  = sb.pop_front();
        act = it.is_busy ? {7'b0, busy} : rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input int n,
                    input bit s = 1'b1, input bit w = 1'b1, input bit o = 1'b0);
    @(posedge clk); #1;
    addr = a; wdata = d; sel = s; wen = w; oen = o;
    repeat (n) @(posedge clk);
    #1; sel = 1'b0; wen = 1'b0; oen = 1'b0;
  endtask

  task automatic rd_expect(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    addr = a; sel = 1'b1; oen = 1'b1; wen = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    it.exp = e; it.is_busy = 1'b0; it.tag = tag;
    sb.push_back(it);
    mon_go = 1'b1;
    @(posedge clk); #1;
    mon_go = 1'b0; sel = 1'b0; oen = 1'b0;
  endtask

  task automatic busy_expect(input bit e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    it.exp = {7'b0, e}; it.is_busy = 1'b1; it.tag = tag;
    sb.push_back(it);
    mon_go = 1'b1;
    @(posedge clk); #1;
    mon_go = 1'b0;
  endtask

  initial begin
    idle(5); #1; rst = 1'b0;
    idle(2);
    // R1 reset state
    busy_expect(1'b0, "R1 busy after reset");
    rd_expect(10'd0, 8'h00, "R1 read addr0");
    rd_expect(10'd133, 8'h00, "R1 read addr133");

    // R4 window restart, R9/R10 status, R6 commit, R7 untouched
    wr(10'd133, 8'hC3, MINP);
    idle(100);
    busy_expect(1'b0, "R4 window open");
    wr(10'd134, 8'h5A, MINP);
    idle(100);
    busy_expect(1'b0, "R4 window restarted");
    wr(10'd135, 8'h91, MINP);
    idle(LIDLE + 10);
    busy_expect(1'b1, "R4 window closed");
    rd_expect(10'd135, 8'h11, "R9 status first read");
    rd_expect(10'd135, 8'h51, "R10 status toggled");
    rd_expect(10'd135, 8'h11, "R10 status toggled back");
    idle(PCYC);
    busy_expect(1'b0, "R6 busy end");
    rd_expect(10'd133, 8'hC3, "R6 commit 133");
    rd_expect(10'd134, 8'h5A, "R6 commit 134");
    rd_expect(10'd135, 8'h91, "R10 true data after");
    rd_expect(10'd136, 8'h00, "R7 unloaded 136");

    // R7 partial rewrite of a page
    wr(10'd260, 8'hAA, MINP);
    wr(10'd261, 8'hBB, MINP);
    idle(LIDLE + PCYC + 20);
    busy_expect(1'b0, "R7 first load done");
    wr(10'd261, 8'h77, MINP);
    idle(LIDLE + PCYC + 20);
    rd_expect(10'd260, 8'hAA, "R7 kept 260");
    rd_expect(10'd261, 8'h77, "R7 rewritten 261");

    // R2 glitch filter
    wr(10'd300, 8'h3C, MINP - 1);
    idle(LIDLE + 20);
    busy_expect(1'b0, "R2 short pulse no load");
    rd_expect(10'd300, 8'h00, "R2 short pulse no data");
    wr(10'd300, 8'h3C, MINP);
    idle(LIDLE + 20);
    busy_expect(1'b1, "R2 exact pulse accepted");
    idle(PCYC);
    rd_expect(10'd300, 8'h3C, "R2 exact pulse data");

    // R3 gated strobes
    wr(10'd400, 8'hE7, 6, 1'b1, 1'b1, 1'b1);
    wr(10'd400, 8'hE7, 6, 1'b0, 1'b1, 1'b0);
    wr(10'd400, 8'hE7, 6, 1'b1, 1'b0, 1'b0);
    idle(LIDLE + 20);
    busy_expect(1'b0, "R3 gated no load");
    rd_expect(10'd400, 8'h00, "R3 gated no data");

    // R5 foreign page dropped, R8 writes during programming ignored
    wr(10'd513, 8'h21, MINP);
    idle(150);
    wr(10'd641, 8'h42, MINP);
    idle(85);
    busy_expect(1'b1, "R5 timer not restarted");
    wr(10'd514, 8'h99, 5);
    idle(PCYC);
    busy_expect(1'b0, "R8 cycle ended");
    rd_expect(10'd513, 8'h21, "R5 own page byte");
    rd_expect(10'd641, 8'h00, "R5 foreign byte dropped");
    rd_expect(10'd514, 8'h00, "R8 write in prog ignored");
    idle(LIDLE + 20);
    busy_expect(1'b0, "R8 no deferred load");

    // R11 repeated address, R9 with top bit 0
    wr(10'd700, 8'h01, MINP);
    wr(10'd700, 8'h02, MINP);
    idle(LIDLE + 10);
    rd_expect(10'd700, 8'h82, "R9 status top bit clear");
    idle(PCYC);
    rd_expect(10'd700, 8'h02, "R11 last byte wins");

    idle(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule